// File: doc/BRIEF.md
# Parallel ADC Conversion Controller

This block sits on the host side of a successive-approximation converter that has a parallel result bus. It runs one sample on request. It drops the conversion-start line to begin a conversion. It then watches the converter's busy flag rise and fall through a two-flop synchronizer. After that it asserts the active-low chip-select and read strobes together, latches the result word and delivers it with a one-cycle valid pulse.

A power-down mode can be chosen per sample. In that mode conversion-start stays low after the result is taken, so the converter drops into its own sleep state. Before the next sample the controller raises the line to wake the converter. It waits a programmable settling count and only then produces the next falling edge.

Two timeouts protect the host:
- If busy never appears, the controller flags an error and returns to idle.
- If busy never clears, it does the same.

Requests that arrive while a sample is in progress are dropped and counted.

Top module: `adc_conv_ctrl`

## Requirements
- R1: While reset is held and right after it, conversion-start and both strobes are high, and valid, error and the overrun count are zero.
- R2: A request accepted when the converter is awake drives conversion-start low on the next clock. In normal mode the line stays low for exactly CONV_LOW_CYC clocks (default 4) and then returns high.
- R3: The busy pin is sampled through SYNC_STAGES flops (default 2). Both strobes go low on the (SYNC_STAGES+1)-th clock after busy falls and stay low for RD_DLY clocks (default 2). Valid is high after the (SYNC_STAGES+1+RD_DLY)-th clock after the fall.
- R4: The word on smp_data equals the converter bus as seen while the strobes are low. Chip-select and read always carry the same level.
- R5: Valid is high for exactly one clock per captured sample. smp_data holds its value until the next capture.
- R6: With power-down selected, conversion-start stays low after the capture. The next request raises it for exactly WAKE_CYC clocks (default 250, 1 us at 250 MHz) before it falls to start the conversion.
- R7: If the synchronized busy is not seen within 4+SYNC_STAGES clocks of the conversion-start fall (6 by default), err_pulse is high for one clock. At that point conversion-start and the strobes are high and no valid is given. The next request is then served normally.
- R8: If busy is still high TIMEOUT clocks after the synchronized busy rise, err_pulse is high for one clock. That is SYNC_STAGES+1+TIMEOUT clocks after the pin rose, and it comes with no valid.
- R9: A request seen on any clock while the controller is not idle starts nothing and adds one to overrun_cnt. The count saturates at all ones (255 for 8 bits).
- R10: TIMEOUT equals (DATA_W+2)*CONV_CLK_DIV + TIMEOUT_MARGIN, which is 72 clocks for the 12-bit default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_req | input | 1 | Request one sample (sampled each clock) |
| pwr_down_en | input | 1 | Leave converter asleep after this sample |
| adc_busy | input | 1 | Converter busy flag, asynchronous |
| adc_data | input | DATA_W | Converter parallel result bus |
| adc_convst | output | 1 | Conversion start, falling edge starts a conversion |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_rd_n | output | 1 | Active-low read strobe |
| smp_valid | output | 1 | One-clock pulse with each captured sample |
| smp_data | output | DATA_W | Last captured result |
| err_pulse | output | 1 | One-clock pulse on a busy timeout |
| overrun_cnt | output | OVR_W | Saturating count of ignored requests |

## Verification
A table of samples is run with different bus words and busy response delays of 1 to 3 clocks. The words are all zeros, all ones, alternating patterns, and single high or low bits. Wrong bit order, a word taken outside the strobe window, or latency that depends on the busy delay all show up as mismatches. Normal and power-down samples are interleaved in every order, so that a wake phase appears exactly when the previous sample left the converter asleep. Directed runs cover a silent converter, a stuck busy, requests during a conversion and a request held high through a whole wake-and-convert cycle, which drives the overrun count to saturation.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_CONV,
    ST_BUSY,
    ST_READ
  } seq_state_e;

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_async,
  output logic busy_sync
);

  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic stage_d;
    if (g == 0) begin : g_first
      assign stage_d = busy_async;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= 1'b0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign busy_sync = stage_q[STAGES-1];

endmodule

// File: rtl/adc_ovr_counter.sv
module adc_ovr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = hit && (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_ovr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cnt_q));

  assert_ovr_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int CONV_LOW_CYC = 4,
  parameter int WAKE_CYC     = 250,
  parameter int RD_DLY       = 2,
  parameter int RISE_LIMIT   = 6,
  parameter int TIMEOUT      = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              pd_en,
  input  logic              busy_s,
  input  logic [DATA_W-1:0] bus_data,
  output logic              convst,
  output logic              strobe_n,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              err,
  output logic              req_ignored
);

  localparam int LIM_A  = (WAKE_CYC > TIMEOUT) ? WAKE_CYC : TIMEOUT;
  localparam int LIM_B  = (RISE_LIMIT > RD_DLY) ? RISE_LIMIT : RD_DLY;
  localparam int LIM    = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int CNT_W  = $clog2(LIM + 1);
  localparam int PCNT_W = $clog2(CONV_LOW_CYC + 1);

  localparam logic [CNT_W-1:0]  WAKE_LAST = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0]  RISE_LAST = CNT_W'(RISE_LIMIT - 1);
  localparam logic [CNT_W-1:0]  TMO_LAST  = CNT_W'(TIMEOUT - 1);
  localparam logic [CNT_W-1:0]  RD_LAST   = CNT_W'(RD_DLY - 1);
  localparam logic [PCNT_W-1:0] LOW_LAST  = PCNT_W'(CONV_LOW_CYC - 1);
  localparam logic [PCNT_W-1:0] LOW_FULL  = PCNT_W'(CONV_LOW_CYC);

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic              pd_q, pd_d;
  logic              asleep_q, asleep_d;
  logic              convst_q, convst_d;
  logic              strobe_q, strobe_d;
  logic              valid_q, valid_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;
  logic              pulse_level;

  // level of conversion-start while a conversion is under way
  assign pulse_level = pd_q ? 1'b0 : (pcnt_q >= LOW_LAST);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    pcnt_d   = (pcnt_q == LOW_FULL) ? pcnt_q : pcnt_q + PCNT_W'(1);
    pd_d     = pd_q;
    asleep_d = asleep_q;
    convst_d = convst_q;
    strobe_d = 1'b1;
    valid_d  = 1'b0;
    err_d    = 1'b0;
    data_en  = 1'b0;
    data_d   = bus_data;
    unique case (st_q)
      ST_IDLE: begin
        convst_d = !asleep_q;
        if (req) begin
          pd_d  = pd_en;
          cnt_d = '0;
          if (asleep_q) begin
            st_d     = ST_WAKE;
            convst_d = 1'b1;
          end else begin
            st_d     = ST_CONV;
            convst_d = 1'b0;
            pcnt_d   = '0;
          end
        end
      end
      ST_WAKE: begin
        convst_d = 1'b1;
        if (cnt_q == WAKE_LAST) begin
          st_d     = ST_CONV;
          convst_d = 1'b0;
          cnt_d    = '0;
          pcnt_d   = '0;
          asleep_d = 1'b0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_CONV: begin
        convst_d = pulse_level;
        if (busy_s) begin
          st_d  = ST_BUSY;
          cnt_d = '0;
        end else if (cnt_q == RISE_LAST) begin
          st_d     = ST_IDLE;
          err_d    = 1'b1;
          convst_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_BUSY: begin
        convst_d = pulse_level;
        if (!busy_s) begin
          st_d     = ST_READ;
          strobe_d = 1'b0;
          cnt_d    = '0;
        end else if (cnt_q == TMO_LAST) begin
          st_d     = ST_IDLE;
          err_d    = 1'b1;
          convst_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_READ: begin
        convst_d = pulse_level;
        if (cnt_q == RD_LAST) begin
          st_d     = ST_IDLE;
          data_en  = 1'b1;
          valid_d  = 1'b1;
          asleep_d = pd_q;
          convst_d = !pd_q;
        end else begin
          strobe_d = 1'b0;
          cnt_d    = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        st_d     = ST_IDLE;
        convst_d = 1'b1;
        asleep_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      pcnt_q   <= '0;
      pd_q     <= 1'b0;
      asleep_q <= 1'b0;
      convst_q <= 1'b1;
      strobe_q <= 1'b1;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      pcnt_q   <= pcnt_d;
      pd_q     <= pd_d;
      asleep_q <= asleep_d;
      convst_q <= convst_d;
      strobe_q <= strobe_d;
      valid_q  <= valid_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign convst      = convst_q;
  assign strobe_n    = strobe_q;
  assign valid       = valid_q;
  assign data        = data_q;
  assign err         = err_q;
  assign req_ignored = req && (st_q != ST_IDLE);

  // consecutive low cycles of conversion-start, for the width check
  logic [PCNT_W-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_run_q <= '0;
    else if (convst_q)      low_run_q <= '0;
    else if (low_run_q != LOW_FULL) low_run_q <= low_run_q + PCNT_W'(1);
  end

  assert_convst_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(convst_q) && !err_q) |-> (low_run_q == LOW_FULL));

  assert_strobe_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_q) |-> !$past(busy_s));

  assert_capture_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> !$past(strobe_q));

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  assert_sleep_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && pd_q) |-> !convst_q);

  assert_err_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (convst_q && strobe_q && !valid_q));

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int DATA_W         = 12,
  parameter int CONV_CLK_DIV   = 4,
  parameter int CONV_LOW_CYC   = 4,
  parameter int WAKE_CYC       = 250,
  parameter int RD_DLY         = 2,
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_MARGIN = 16,
  parameter int OVR_W          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_req,
  input  logic              pwr_down_en,
  input  logic              adc_busy,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_convst,
  output logic              adc_cs_n,
  output logic              adc_rd_n,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              err_pulse,
  output logic [OVR_W-1:0]  overrun_cnt
);

  // converter clocks per conversion: data bits plus two
  localparam int CONV_CYCLES = DATA_W + 2;
  localparam int TIMEOUT     = CONV_CYCLES * CONV_CLK_DIV + TIMEOUT_MARGIN;
  localparam int RISE_LIMIT  = 4 + SYNC_STAGES;

  logic busy_s;
  logic strobe_n;
  logic req_ignored;

  adc_busy_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_async (adc_busy),
    .busy_sync  (busy_s)
  );

  adc_seq_fsm #(
    .DATA_W       (DATA_W),
    .CONV_LOW_CYC (CONV_LOW_CYC),
    .WAKE_CYC     (WAKE_CYC),
    .RD_DLY       (RD_DLY),
    .RISE_LIMIT   (RISE_LIMIT),
    .TIMEOUT      (TIMEOUT)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (sample_req),
    .pd_en       (pwr_down_en),
    .busy_s      (busy_s),
    .bus_data    (adc_data),
    .convst      (adc_convst),
    .strobe_n    (strobe_n),
    .valid       (smp_valid),
    .data        (smp_data),
    .err         (err_pulse),
    .req_ignored (req_ignored)
  );

  adc_ovr_counter #(
    .W (OVR_W)
  ) u_ovr (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (req_ignored),
    .count (overrun_cnt)
  );

  assign adc_cs_n = strobe_n;
  assign adc_rd_n = strobe_n;

endmodule

// File: tb/adc_conv_ctrl_test.sv
module adc_conv_ctrl_test;

  localparam int DW       = 12;
  localparam int RD       = 2;
  localparam int LOW      = 4;
  localparam int WAKE     = 250;
  localparam int DIV      = 4;
  localparam int SYNC     = 2;
  localparam int BUSY_HI  = (DW + 2) * DIV;
  localparam int TMO      = BUSY_HI + 16;
  localparam int RISE_LIM = 4 + SYNC;
  localparam int NVEC     = 8;

  // {power-down, busy delay, bus word}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 4'd1, 12'h000},
    {1'b0, 4'd3, 12'hFFF},
    {1'b1, 4'd2, 12'hA5A},
    {1'b1, 4'd1, 12'h5A5},
    {1'b0, 4'd2, 12'h800},
    {1'b0, 4'd3, 12'h001},
    {1'b1, 4'd3, 12'h7E1},
    {1'b0, 4'd1, 12'h3C3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_req = 1'b0;
  logic          pwr_down_en = 1'b0;
  logic          adc_busy = 1'b0;
  logic [DW-1:0] adc_data;
  logic          adc_convst, adc_cs_n, adc_rd_n, smp_valid, err_pulse;
  logic [DW-1:0] smp_data;
  logic [7:0]    overrun_cnt;

  always #2 clk = ~clk;

  adc_conv_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_req  (sample_req),
    .pwr_down_en (pwr_down_en),
    .adc_busy    (adc_busy),
    .adc_data    (adc_data),
    .adc_convst  (adc_convst),
    .adc_cs_n    (adc_cs_n),
    .adc_rd_n    (adc_rd_n),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .err_pulse   (err_pulse),
    .overrun_cnt (overrun_cnt)
  );

  // converter model: mode 0 normal, 1 silent, 2 busy stuck, 3 force idle
  int            mode = 0;
  int            mdly = 1;
  logic [DW-1:0] mdata = '0;
  int            phase = 0;
  int            mcnt = 0;
  logic          conv_prev = 1'b1;
  int            t_fall = 0, t_brise = 0, t_bfall = 0;

  assign adc_data = (!adc_cs_n && !adc_rd_n) ? mdata : ~mdata;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n || mode == 3) begin
      adc_busy  = 1'b0;
      phase     = 0;
      conv_prev = adc_convst;
    end else begin
      if (conv_prev && !adc_convst) begin
        t_fall = cyc;
        if (mode != 1) begin
          phase = 1;
          mcnt  = 0;
        end
      end else if (phase == 1) begin
        mcnt = mcnt + 1;
        if (mcnt == mdly) begin
          adc_busy = 1'b1;
          t_brise  = cyc;
          phase    = 2;
          mcnt     = 0;
        end
      end else if (phase == 2) begin
        mcnt = mcnt + 1;
        if (mode != 2 && mcnt == BUSY_HI) begin
          adc_busy = 1'b0;
          t_bfall  = cyc;
          phase    = 0;
        end
      end
      conv_prev = adc_convst;
    end
  end

  // output monitor
  int            nvalid = 0, nerr = 0, t_valid = 0, t_err = 0;
  logic [DW-1:0] vdata = '0;
  int            lowrun = 0, last_low = 0, highrun = 0, last_high = 0;
  int            strun = 0, last_strobe = 0, strobe_split = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (smp_valid) begin
        nvalid  = nvalid + 1;
        vdata   = smp_data;
        t_valid = cyc;
      end
      if (err_pulse) begin
        nerr  = nerr + 1;
        t_err = cyc;
      end
      if (!adc_convst) begin
        lowrun = lowrun + 1;
        if (highrun > 0) last_high = highrun;
        highrun = 0;
      end else begin
        highrun = highrun + 1;
        if (lowrun > 0) last_low = lowrun;
        lowrun = 0;
      end
      if (!adc_cs_n) strun = strun + 1;
      else begin
        if (strun > 0) last_strobe = strun;
        strun = 0;
      end
      if (adc_cs_n != adc_rd_n) strobe_split = strobe_split + 1;
    end
  end

  int total = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_valid(input int n0);
    for (int k = 0; k < 800 && nvalid == n0; k++) tick();
  endtask

  task automatic run_sample(input bit pd, input int dly, input logic [DW-1:0] d, input bit woke);
    int n0;
    pwr_down_en = pd;
    mdly        = dly;
    mdata       = d;
    mode        = 0;
    n0          = nvalid;
    sample_req  = 1'b1;
    tick();
    sample_req  = 1'b0;
    wait_valid(n0);
    check(nvalid == n0 + 1, "R2 sample produced", nvalid - n0, 1);
    check(vdata == d, "R4 captured word", int'(vdata), int'(d));
    check(t_valid - t_bfall == SYNC + 1 + RD, "R3 valid latency", t_valid - t_bfall, SYNC + 1 + RD);
    check(last_strobe == RD, "R3 strobe width", last_strobe, RD);
    if (woke) check(last_high == WAKE, "R6 wake width", last_high, WAKE);
    if (!pd) begin
      check(last_low == LOW, "R2 start pulse width", last_low, LOW);
      check(adc_convst == 1'b1, "R2 start high after", int'(adc_convst), 1);
    end
    tick();
    check(smp_valid == 1'b0, "R5 valid one clock", int'(smp_valid), 0);
    tick();
    tick();
    check(smp_data == d, "R5 data held", int'(smp_data), int'(d));
    if (pd) check(adc_convst == 1'b0, "R6 asleep after capture", int'(adc_convst), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    bit prev_pd;
    int n0, e0, ov0;
    prev_pd = 1'b0;
    repeat (3) tick();
    // R1 reset values, during and after reset
    check(adc_convst == 1'b1, "R1 start idle", int'(adc_convst), 1);
    check(adc_cs_n && adc_rd_n, "R1 strobes idle", int'(adc_cs_n & adc_rd_n), 1);
    rst_n = 1'b1;
    repeat (2) tick();
    check(!smp_valid && !err_pulse, "R1 no pulses", int'(smp_valid | err_pulse), 0);
    check(overrun_cnt == 8'd0, "R1 overrun zero", int'(overrun_cnt), 0);
    check(adc_convst == 1'b1, "R1 start idle after", int'(adc_convst), 1);

    for (int i = 0; i < NVEC; i++) begin
      run_sample(VEC[i][16], int'(VEC[i][15:12]), VEC[i][11:0], prev_pd);
      prev_pd = VEC[i][16];
    end

    // R9: requests during a conversion are ignored and counted
    ov0 = int'(overrun_cnt);
    n0  = nvalid;
    pwr_down_en = 1'b0;
    mdly = 2;
    mdata = 12'h9C3;
    sample_req = 1'b1;
    tick();
    sample_req = 1'b0;
    for (int k = 0; k < 3; k++) begin
      repeat (8) tick();
      sample_req = 1'b1;
      tick();
      sample_req = 1'b0;
    end
    wait_valid(n0);
    repeat (30) tick();
    check(int'(overrun_cnt) == ov0 + 3, "R9 overrun count", int'(overrun_cnt), ov0 + 3);
    check(nvalid == n0 + 1, "R9 one sample only", nvalid - n0, 1);
    check(vdata == 12'h9C3, "R4 word after overrun", int'(vdata), 'h9C3);

    // R7: converter never raises busy
    e0 = nerr;
    n0 = nvalid;
    mode = 1;
    sample_req = 1'b1;
    tick();
    sample_req = 1'b0;
    for (int k = 0; k < 100 && nerr == e0; k++) tick();
    check(nerr == e0 + 1, "R7 error raised", nerr - e0, 1);
    check(t_err - t_fall == RISE_LIM, "R7 rise window", t_err - t_fall, RISE_LIM);
    check(adc_convst && adc_cs_n, "R7 lines released", int'(adc_convst & adc_cs_n), 1);
    check(nvalid == n0, "R7 no valid", nvalid - n0, 0);
    tick();
    check(err_pulse == 1'b0, "R7 error one clock", int'(err_pulse), 0);
    mode = 0;
    run_sample(1'b0, 2, 12'h1E7, 1'b0);

    // R8 and R10: busy stuck high
    e0 = nerr;
    n0 = nvalid;
    mode = 2;
    mdly = 1;
    sample_req = 1'b1;
    tick();
    sample_req = 1'b0;
    for (int k = 0; k < 400 && nerr == e0; k++) tick();
    check(nerr == e0 + 1, "R8 error raised", nerr - e0, 1);
    check(t_err - t_brise == SYNC + 1 + TMO, "R10 timeout length", t_err - t_brise, SYNC + 1 + TMO);
    check(nvalid == n0, "R8 no valid", nvalid - n0, 0);
    mode = 3;
    repeat (4) tick();
    mode = 0;
    run_sample(1'b0, 3, 12'hE18, 1'b0);

    // R9 saturation: request held through a power-down and a wake cycle
    run_sample(1'b1, 1, 12'h2B4, 1'b0);
    n0 = nvalid;
    mdata = 12'h4D2;
    pwr_down_en = 1'b1;
    sample_req = 1'b1;
    wait_valid(n0);
    sample_req = 1'b0;
    tick();
    check(overrun_cnt == 8'hFF, "R9 saturation", int'(overrun_cnt), 255);
    check(vdata == 12'h4D2, "R4 word after wake", int'(vdata), 'h4D2);
    check(last_high == WAKE, "R6 wake width held request", last_high, WAKE);

    check(strobe_split == 0, "R4 strobes equal", strobe_split, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

endmodule